// File: doc/BRIEF.md
# Fetch, Call and Interrupt Sequencer

This block holds the program counter and stack pointer of a processor with 16-bit words and word addressing. It reads instruction words from a single synchronous memory port and hands each one to the decoder as a one-cycle pulse. It also performs the memory traffic for subroutine call and return, for discarding a stack word, and for entering and leaving interrupts. The decoder answers each issued word in the cycle the pulse is high, with at most one strobe: call (with a target address), return, return-from-interrupt, or drop.

There is one interrupt request line, and each request carries a 16-bit cause code. Every accepted interrupt jumps to address 0; there is no vector table. The entry frame holds the return address, the status word taken from the datapath, and the cause code, with the cause word on top. A handler reads the cause from the top of the stack to choose its routine, then drops that word before it returns. The return-from-interrupt sequence gives the saved status back to the datapath and reloads the program counter.

Top module: `fcis_seq`

## Requirements
- R1: Reset clears the program counter, the stack pointer and the restored status. While reset is held, pc_out and status_out read 0 and no write is made. In the first cycle after reset, the memory port addresses word 0.
- R2: Each instruction is read from the address held in the program counter and presented on instr_out with instr_valid high for exactly one cycle. In that cycle pc_out already reads the fetch address plus one.
- R3: A push first decrements the stack pointer and then writes at the new value. A pop reads at the stack pointer and then increments it. After reset, the first push lands at 0xFFFF and later pushes descend.
- R4: A call strobe writes the return address (the call word's address plus one) to the stack. The next fetch is then made from call_target.
- R5: A return strobe pops the top word into the program counter, and the next fetch is made from that address.
- R6: An accepted interrupt makes three writes in consecutive cycles at descending addresses: the return address, then status_in, then the cause code. The next fetch is then made from address 0.
- R7: An interrupt is taken only in an instruction-valid cycle in which no decoder strobe is present. It is never taken during a call, return, entry or return-from-interrupt sequence.
- R8: A request that arrives while an entry frame is being written stays pending, together with its own cause code. It is taken at the first later boundary that qualifies under R7.
- R9: A drop strobe discards the top stack word by incrementing the stack pointer, with no memory write.
- R10: A return-from-interrupt strobe pops the status word onto status_out, with status_load high for one cycle, and then pops the program counter. Execution resumes at the saved return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| irq_req | input | 1 | Interrupt request pulse |
| irq_cause | input | 16 | Cause code that goes with irq_req |
| dec_call | input | 1 | Decoder: call to call_target |
| dec_ret | input | 1 | Decoder: return from subroutine |
| dec_reti | input | 1 | Decoder: return from interrupt |
| dec_drop | input | 1 | Decoder: discard top stack word |
| call_target | input | 16 | Call destination address |
| status_in | input | 16 | Current status word from the datapath |
| status_out | output | 16 | Status word restored by return-from-interrupt |
| status_load | output | 1 | One-cycle pulse when status_out is updated |
| instr_out | output | 16 | Issued instruction word |
| instr_valid | output | 1 | One-cycle pulse marking an issued instruction |
| pc_out | output | 16 | Next program counter |

## Verification
The hardest case to reach from the ports is a second request that arrives in the middle of an entry frame. Under R7 it must then wait through the handler's drop and return-from-interrupt boundaries before it is taken. The bench raises the second request as soon as it sees the first frame write. When that frame is complete, it rewrites the two words at address 0 so that they become the handler. It then checks that the second frame saves the address just after the resumed instruction, uses the second cause code and the newer status, and starts again at 0xFFFF, which shows that the drop and the return restored the stack pointer.

// File: rtl/fcis_pkg.sv
package fcis_pkg;
  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_PUSH,
    ST_POP_RD,
    ST_POP_WB,
    ST_ENT_PC,
    ST_ENT_ST,
    ST_ENT_CA,
    ST_RTI_A,
    ST_RTI_B,
    ST_RTI_C
  } seq_state_t;
endpackage

// File: rtl/fcis_stack_ptr.sv
module fcis_stack_ptr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dec,
  input  logic         inc,
  output logic [W-1:0] sp
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (dec) begin
      sp <= sp - ONE;
    end else if (inc) begin
      sp <= sp + ONE;
    end
  end

  // R3: the pointer moves by exactly one word per push or pop
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    dec |=> sp == $past(sp) - ONE);
  p_pop_step_r3: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec) |=> sp == $past(sp) + ONE);
endmodule

// File: rtl/fcis_irq_hold.sv
module fcis_irq_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req,
  input  logic [W-1:0] cause,
  input  logic         take,
  output logic         pend,
  output logic [W-1:0] frame_cause
);
  logic [W-1:0] held_cause;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend        <= 1'b0;
      held_cause  <= '0;
      frame_cause <= '0;
    end else begin
      if (req) begin
        pend       <= 1'b1;
        held_cause <= cause;
      end else if (take) begin
        pend <= 1'b0;
      end
      if (take) begin
        frame_cause <= held_cause;
      end
    end
  end

  // R8: a request is never lost, and it is kept until it is taken
  p_req_held_r8: assert property (@(posedge clk) disable iff (rst)
    req |=> pend);
  p_pend_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (pend && !take) |=> pend);
endmodule

// File: rtl/fcis_fetch.sv
module fcis_fetch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue,
  input  logic [W-1:0] rdata,
  input  logic         pc_inc,
  input  logic         pc_load,
  input  logic [W-1:0] pc_val,
  output logic [W-1:0] pc,
  output logic [W-1:0] instr,
  output logic         valid
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      instr <= '0;
      valid <= 1'b0;
    end else begin
      valid <= issue;
      if (issue) begin
        instr <= rdata;
      end
      if (pc_load) begin
        pc <= pc_val;
      end else if (pc_inc) begin
        pc <= pc + ONE;
      end
    end
  end

  // R2: the issue pulse lasts one cycle and follows a one-word advance
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (issue && !pc_load) |=> (valid && pc == $past(pc) + ONE));
endmodule

// File: rtl/fcis_seq.sv
module fcis_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] mem_addr,
  output logic         mem_we,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         irq_req,
  input  logic [W-1:0] irq_cause,
  input  logic         dec_call,
  input  logic         dec_ret,
  input  logic         dec_reti,
  input  logic         dec_drop,
  input  logic [W-1:0] call_target,
  input  logic [W-1:0] status_in,
  output logic [W-1:0] status_out,
  output logic         status_load,
  output logic [W-1:0] instr_out,
  output logic         instr_valid,
  output logic [W-1:0] pc_out
);
  import fcis_pkg::*;

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  seq_state_t   state, nstate;
  logic [W-1:0] sp, pc, tgt_q, frame_cause, pc_val;
  logic         pend, take, sp_dec, sp_inc, pc_inc, pc_load, issue, st_grab;

  fcis_stack_ptr #(.W(W)) u_sp (
    .clk(clk), .rst(rst), .dec(sp_dec), .inc(sp_inc), .sp(sp)
  );

  fcis_irq_hold #(.W(W)) u_irq (
    .clk(clk), .rst(rst), .req(irq_req), .cause(irq_cause),
    .take(take), .pend(pend), .frame_cause(frame_cause)
  );

  fcis_fetch #(.W(W)) u_fetch (
    .clk(clk), .rst(rst), .issue(issue), .rdata(mem_rdata),
    .pc_inc(pc_inc), .pc_load(pc_load), .pc_val(pc_val),
    .pc(pc), .instr(instr_out), .valid(instr_valid)
  );

  assign pc_out = pc;

  always_comb begin
    nstate  = state;
    take    = 1'b0;
    sp_dec  = 1'b0;
    sp_inc  = 1'b0;
    pc_inc  = 1'b0;
    pc_load = 1'b0;
    pc_val  = '0;
    issue   = 1'b0;
    st_grab = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = pc;
    mem_addr  = pc;
    unique case (state)
      ST_FETCH:  nstate = ST_DECODE;
      ST_DECODE: begin
        issue  = 1'b1;
        pc_inc = 1'b1;
        nstate = ST_EXEC;
      end
      ST_EXEC: begin
        if (dec_call) begin
          sp_dec = 1'b1;
          nstate = ST_PUSH;
        end else if (dec_ret) begin
          nstate = ST_POP_RD;
        end else if (dec_reti) begin
          nstate = ST_RTI_A;
        end else if (dec_drop) begin
          sp_inc = 1'b1;
          nstate = ST_FETCH;
        end else if (pend) begin
          take   = 1'b1;
          sp_dec = 1'b1;
          nstate = ST_ENT_PC;
        end else begin
          nstate = ST_FETCH;
        end
      end
      ST_PUSH: begin
        mem_addr = sp;
        mem_we   = 1'b1;
        pc_load  = 1'b1;
        pc_val   = tgt_q;
        nstate   = ST_FETCH;
      end
      ST_POP_RD: begin
        mem_addr = sp;
        sp_inc   = 1'b1;
        nstate   = ST_POP_WB;
      end
      ST_POP_WB: begin
        pc_load = 1'b1;
        pc_val  = mem_rdata;
        nstate  = ST_FETCH;
      end
      ST_ENT_PC: begin
        mem_addr = sp;
        mem_we   = 1'b1;
        sp_dec   = 1'b1;
        nstate   = ST_ENT_ST;
      end
      ST_ENT_ST: begin
        mem_addr  = sp;
        mem_we    = 1'b1;
        mem_wdata = status_in;
        sp_dec    = 1'b1;
        nstate    = ST_ENT_CA;
      end
      ST_ENT_CA: begin
        mem_addr  = sp;
        mem_we    = 1'b1;
        mem_wdata = frame_cause;
        pc_load   = 1'b1;
        pc_val    = '0;
        nstate    = ST_FETCH;
      end
      ST_RTI_A: begin
        mem_addr = sp;
        sp_inc   = 1'b1;
        nstate   = ST_RTI_B;
      end
      ST_RTI_B: begin
        mem_addr = sp;
        sp_inc   = 1'b1;
        st_grab  = 1'b1;
        nstate   = ST_RTI_C;
      end
      ST_RTI_C: begin
        pc_load = 1'b1;
        pc_val  = mem_rdata;
        nstate  = ST_FETCH;
      end
      default: nstate = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_FETCH;
      tgt_q       <= '0;
      status_out  <= '0;
      status_load <= 1'b0;
    end else begin
      state       <= nstate;
      status_load <= st_grab;
      if (state == ST_EXEC && dec_call) begin
        tgt_q <= call_target;
      end
      if (st_grab) begin
        status_out <= mem_rdata;
      end
    end
  end

  // R7: interrupts are taken only at an issued-instruction boundary
  p_take_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    take |-> (instr_valid && !dec_call && !dec_ret && !dec_reti && !dec_drop));
  // R6: back-to-back frame writes descend by one word
  p_frame_descend_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) - ONE);
  // R6: after the cause word the fetch restarts at zero
  p_entry_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ENT_CA) |=> pc_out == '0);
  // R3: every write lands at the current stack pointer
  p_push_at_sp_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_addr == sp);
  // R10: the restored status is the word read just before the pulse
  p_status_word_r10: assert property (@(posedge clk) disable iff (rst)
    status_load |-> status_out == $past(mem_rdata));
endmodule

// File: tb/fcis_seq_tb.sv
module fcis_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, status_out, instr_out, pc_out;
  logic        mem_we, status_load, instr_valid;
  logic        irq_req = 1'b0;
  logic [15:0] irq_cause = '0;
  logic [15:0] status_in = '0;
  logic        dec_call, dec_ret, dec_reti, dec_drop;
  logic [15:0] call_target;

  always #4 clk = ~clk;

  fcis_seq u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_req(irq_req),
    .irq_cause(irq_cause), .dec_call(dec_call), .dec_ret(dec_ret),
    .dec_reti(dec_reti), .dec_drop(dec_drop), .call_target(call_target),
    .status_in(status_in), .status_out(status_out), .status_load(status_load),
    .instr_out(instr_out), .instr_valid(instr_valid), .pc_out(pc_out)
  );

  // bench decoder: opcode in top nibble, 1 call, 2 ret, 3 reti, 4 drop
  always_comb begin
    dec_call    = instr_valid && instr_out[15:12] == 4'h1;
    dec_ret     = instr_valid && instr_out[15:12] == 4'h2;
    dec_reti    = instr_valid && instr_out[15:12] == 4'h3;
    dec_drop    = instr_valid && instr_out[15:12] == 4'h4;
    call_target = {4'h0, instr_out[11:0]};
  end

  // small memory: low code region and high stack region
  logic [15:0] mem [256];
  function automatic int midx(input logic [15:0] a);
    return {a[15], a[6:0]};
  endfunction
  always @(posedge clk) begin
    if (mem_we) mem[midx(mem_addr)] <= mem_wdata;
    mem_rdata <= mem[midx(mem_addr)];
  end

  int n_chk = 0, n_bad = 0;
  logic [15:0] wr_a [64], wr_d [64], is_i [64], is_p [64], st_v [8];
  int wr_iss [64];
  int wr_n, is_n, st_n;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we && wr_n < 64) begin
        wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_wdata; wr_iss[wr_n] = is_n;
        wr_n = wr_n + 1;
      end
      if (instr_valid && is_n < 64) begin
        is_i[is_n] = instr_out; is_p[is_n] = pc_out; is_n = is_n + 1;
      end
      if (status_load && st_n < 8) begin
        st_v[st_n] = status_out; st_n = st_n + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wr_n = 0; is_n = 0; st_n = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 pc", pc_out, 16'h0000);
    chk("R1 status", status_out, 16'h0000);
    chk("R1 we", {15'b0, mem_we}, 16'h0000);
    rst = 1'b0;
    #1;
    chk("R1 first fetch", mem_addr, 16'h0000);
  endtask

  task automatic wait_iss(input int n);
    for (int k = 0; k < 3000 && is_n < n; k++) @(negedge clk);
  endtask

  task automatic wait_wr(input int n);
    for (int k = 0; k < 3000 && wr_n < n; k++) @(negedge clk);
  endtask

  int p1, b;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;

    // R2: sweep of plain words
    for (int i = 0; i < 16; i++) mem[i] = 16'((i * 16'h0101) & 16'h0FFF);
    do_reset();
    wait_iss(16);
    for (int i = 0; i < 16; i++) begin
      chk("R2 word", is_i[i], 16'((i * 16'h0101) & 16'h0FFF));
      chk("R2 next pc", is_p[i], 16'(i + 1));
    end
    chk("R2 no write", 16'(wr_n), 16'd0);

    // R3 R4 R5: nested call and return
    for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
    mem[0] = 16'h0001; mem[1] = 16'h1020; mem[2] = 16'h0BBB;
    mem[16'h20] = 16'h1030; mem[16'h21] = 16'h2000; mem[16'h30] = 16'h2000;
    do_reset();
    wait_iss(6);
    chk("R3 first push addr", wr_a[0], 16'hFFFF);
    chk("R4 return addr", wr_d[0], 16'h0002);
    chk("R3 second push addr", wr_a[1], 16'hFFFE);
    chk("R4 nested return addr", wr_d[1], 16'h0021);
    chk("R4 target fetch", is_i[2], 16'h1030);
    chk("R4 target pc", is_p[2], 16'h0021);
    chk("R5 inner ret pc", is_p[3], 16'h0031);
    chk("R5 pop to 0x21", is_i[4], 16'h2000);
    chk("R5 pop to 0x21 pc", is_p[4], 16'h0022);
    chk("R5 outer ret", is_i[5], 16'h0BBB);
    chk("R5 outer ret pc", is_p[5], 16'h0003);
    chk("R3 write count", 16'(wr_n), 16'd2);

    // R6 R7 R8 R9 R10: interrupts with a nested pending request
    for (int i = 0; i < 16; i++) mem[i] = 16'(16'h0111 * (i + 1));
    do_reset();
    status_in = 16'h5A5A;
    wait_iss(1);
    irq_cause = 16'hC0DE; irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;
    wait_wr(1);
    irq_cause = 16'hBEEF; irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;
    wait_wr(3);
    mem[0] = 16'h4000; mem[1] = 16'h3000; status_in = 16'h1234;
    wait_wr(6);
    wait_iss(wr_iss[3] + 3);
    b = wr_iss[0];
    p1 = int'(is_p[b - 1]);
    chk("R6 pc addr", wr_a[0], 16'hFFFF);
    chk("R6 status addr", wr_a[1], 16'hFFFE);
    chk("R6 cause addr", wr_a[2], 16'hFFFD);
    chk("R6 status word", wr_d[1], 16'h5A5A);
    chk("R6 cause word", wr_d[2], 16'hC0DE);
    chk("R6 consecutive", 16'(wr_iss[2] - wr_iss[0]), 16'd0);
    chk("R6 vector zero", is_p[b], 16'h0001);
    chk("R6 handler word", is_i[b], 16'h4000);
    chk("R10 reti issued", is_i[b + 1], 16'h3000);
    chk("R10 resume pc", is_p[b + 2], 16'(p1 + 1));
    chk("R10 resume word", is_i[b + 2], mem[p1]);
    chk("R10 status restored", st_v[0], 16'h5A5A);
    chk("R8 second frame pc", wr_d[3], 16'(p1 + 1));
    chk("R7 not taken in handler", 16'(wr_iss[3]), 16'(b + 3));
    chk("R9 stack restored", wr_a[3], 16'hFFFF);
    chk("R8 second status", wr_d[4], 16'h1234);
    chk("R8 second cause", wr_d[5], 16'hBEEF);
    chk("R8 second handler", is_p[wr_iss[3]], 16'h0001);
    chk("R10 second resume", is_p[wr_iss[3] + 2], 16'(p1 + 2));
    chk("R10 second status", st_v[1], 16'h1234);
    chk("R10 load count", 16'(st_n), 16'd2);

    // R1: reset clears a restored status
    do_reset();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule